// File: doc/BRIEF.md
# ECC Error Address Logging Unit

This unit keeps the memory burst start addresses of ECC error events so that software can inspect them later. Correctable-error events go into a small first-in first-out log of four entries. The log keeps the earliest events, and new events are discarded while it is full. Software reads the oldest stored address through a register and removes it by writing the value 1 to that same register. Stored addresses are never compared with one another, so repeated errors at one location take up repeated entries.

Uncorrectable-error events use a separate single-entry holding register. It captures the address of the first such event and keeps it through all later uncorrectable events until software clears it. After the clear it is armed again and captures the next event. Detecting errors, computing ECC and raising interrupts are done elsewhere. This unit only receives event strobes, each with the burst start address, and offers a plain register read/write port.

Top module: `ecc_addr_log`

## Requirements
- R1: After reset the correctable log is empty (`ce_empty`=1), the uncorrectable register is not holding (`ue_held`=0), and both registers read back as zero.
- R2: A `ce_valid` strobe taken while the log is not full stores `ce_addr` as the newest entry. With `reg_sel`=0, `reg_rdata` shows the oldest stored address (zero-extended) from the cycle after the event clock edge.
- R3: The log holds at most 4 entries. A `ce_valid` strobe taken while 4 entries are stored, with no pop in the same cycle, is discarded and leaves the contents unchanged.
- R4: A write (`reg_wr`=1) with `reg_sel`=0 and `reg_wdata`=1 removes the oldest entry, so the next-oldest entry is shown from the following cycle.
- R5: A write with `reg_sel`=0 and any `reg_wdata` value other than 1 has no effect on the log.
- R6: A pop on an empty log has no effect. An empty log reads as zero with `ce_empty`=1.
- R7: The same address received several times is stored once for each event, and is popped out that same number of times.
- R8: When the log is full and a pop and a `ce_valid` strobe occur in the same cycle, the pop is done first and the new address is stored as the newest entry.
- R9: A `ue_valid` strobe while `ue_held`=0 captures `ue_addr` and sets `ue_held`. With `reg_sel`=1, `reg_rdata` shows the captured address, or zero when nothing is held.
- R10: While `ue_held`=1, later `ue_valid` strobes are ignored and the held address stays unchanged.
- R11: A write of any value with `reg_sel`=1 clears the uncorrectable register. If a `ue_valid` strobe occurs in the same cycle as the clear, its address is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_valid | input | 1 | Correctable-error event strobe |
| ce_addr | input | ADDR_W | Burst start address of the correctable event |
| ue_valid | input | 1 | Uncorrectable-error event strobe |
| ue_addr | input | ADDR_W | Burst start address of the uncorrectable event |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = correctable log, 1 = uncorrectable register |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| ce_empty | output | 1 | Correctable log holds no entries |
| ue_held | output | 1 | Uncorrectable register holds an address |

## Verification
The bench fills the log past its capacity and checks that the fifth address is dropped and not written over the oldest one. A design that wrapped its write pointer would show a wrong head after the following pops. It then issues a pop and an event together on a full log: a design that tested fullness before popping would lose the event, and a design that pushed first would overwrite an entry. Pops on an empty log, writes of values other than 1, and duplicate addresses are all checked through the read port, which catches pointer underflow and any deduplication. On the uncorrectable side the bench checks that a second event cannot replace the held address, and that an event arriving in the same cycle as a clear is captured, not lost.

// File: rtl/eal_pkg.sv
package eal_pkg;

    typedef enum logic {
        SEL_CE = 1'b0,
        SEL_UE = 1'b1
    } eal_sel_e;

    typedef struct packed {
        logic pop;
        logic clr;
    } eal_ctl_t;

    localparam int unsigned POP_CODE = 1;

endpackage

// File: rtl/eal_ce_fifo.sv
module eal_ce_fifo
    import eal_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DEPTH  = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [ADDR_W-1:0]          push_addr,
    input  logic                       pop_req,
    output logic [ADDR_W-1:0]          head,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] mem [DEPTH];
    logic [PW-1:0]     rd_ptr;
    logic [PW-1:0]     wr_ptr;
    logic [CW-1:0]     cnt_q;
    logic              do_pop;
    logic              do_push;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        do_pop  = pop_req && (cnt_q != '0);
        do_push = push && ((cnt_q != CW'(DEPTH)) || do_pop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_pop)
                rd_ptr <= ptr_next(rd_ptr);
            if (do_push)
                wr_ptr <= ptr_next(wr_ptr);
            if (do_push && !do_pop)
                cnt_q <= cnt_q + CW'(1);
            else if (do_pop && !do_push)
                cnt_q <= cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < int'(DEPTH); i++) begin
            if (do_push && (wr_ptr == PW'(i)))
                mem[i] <= push_addr;
        end
    end

    always_comb begin
        empty = (cnt_q == '0);
        head  = empty ? '0 : mem[rd_ptr];
        count = cnt_q;
    end
endmodule

// File: rtl/eal_ue_hold.sv
module eal_ue_hold
    import eal_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              clr,
    output logic              held,
    output logic [ADDR_W-1:0] addr_q
);
    logic              held_q;
    logic [ADDR_W-1:0] a_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
            a_q    <= '0;
        end else if (ev && (!held_q || clr)) begin
            held_q <= 1'b1;
            a_q    <= ev_addr;
        end else if (clr) begin
            held_q <= 1'b0;
            a_q    <= '0;
        end
    end

    always_comb begin
        held   = held_q;
        addr_q = a_q;
    end
endmodule

// File: rtl/eal_reg_if.sv
module eal_reg_if
    import eal_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] ce_head,
    input  logic [ADDR_W-1:0] ue_addr_q,
    output eal_ctl_t          ctl,
    output logic [DATA_W-1:0] reg_rdata
);
    eal_sel_e sel;

    always_comb begin
        sel       = eal_sel_e'(reg_sel);
        ctl.pop   = reg_wr && (sel == SEL_CE) && (reg_wdata == DATA_W'(POP_CODE));
        ctl.clr   = reg_wr && (sel == SEL_UE);
        reg_rdata = (sel == SEL_CE) ? DATA_W'(ce_head) : DATA_W'(ue_addr_q);
    end
endmodule

// File: rtl/ecc_addr_log.sv
module ecc_addr_log
    import eal_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_valid,
    input  logic [ADDR_W-1:0] ce_addr,
    input  logic              ue_valid,
    input  logic [ADDR_W-1:0] ue_addr,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              ce_empty,
    output logic              ue_held
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    eal_ctl_t          ctl;
    logic [ADDR_W-1:0] ce_head;
    logic [ADDR_W-1:0] ue_q;
    logic [CW-1:0]     ce_count;

    eal_reg_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .ce_head   (ce_head),
        .ue_addr_q (ue_q),
        .ctl       (ctl),
        .reg_rdata (reg_rdata)
    );

    eal_ce_fifo #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (ce_valid),
        .push_addr (ce_addr),
        .pop_req   (ctl.pop),
        .head      (ce_head),
        .empty     (ce_empty),
        .count     (ce_count)
    );

    eal_ue_hold #(.ADDR_W(ADDR_W)) u_ue (
        .clk     (clk),
        .rst     (rst),
        .ev      (ue_valid),
        .ev_addr (ue_addr),
        .clr     (ctl.clr),
        .held    (ue_held),
        .addr_q  (ue_q)
    );
endmodule

// File: rtl/eal_checker.sv
module eal_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned CW     = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_valid,
    input logic              ue_valid,
    input logic [ADDR_W-1:0] ue_addr,
    input logic              reg_wr,
    input logic              reg_sel,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              ce_empty,
    input logic              ue_held,
    input logic [CW-1:0]     ce_count,
    input logic [ADDR_W-1:0] ue_q
);
    logic pop_w;
    logic clr_w;
    assign pop_w = reg_wr && !reg_sel && (reg_wdata == DATA_W'(1));
    assign clr_w = reg_wr && reg_sel;

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        ce_count <= CW'(DEPTH));

    a_r6_empty_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (ce_empty && !reg_sel) |-> (reg_rdata == '0));

    a_r6_pop_on_empty: assert property (@(posedge clk) disable iff (rst)
        (ce_empty && !ce_valid) |=> ce_empty);

    a_r2_push_grows: assert property (@(posedge clk) disable iff (rst)
        (ce_valid && !pop_w && ce_count < CW'(DEPTH)) |=> (ce_count == $past(ce_count) + CW'(1)));

    a_r3_full_drop: assert property (@(posedge clk) disable iff (rst)
        (!pop_w && ce_count == CW'(DEPTH)) |=> (ce_count == CW'(DEPTH)));

    a_r8_full_push_pop: assert property (@(posedge clk) disable iff (rst)
        (ce_valid && pop_w && ce_count == CW'(DEPTH)) |=> (ce_count == CW'(DEPTH)));

    a_r9_ue_capture: assert property (@(posedge clk) disable iff (rst)
        (!ue_held && ue_valid) |=> (ue_held && ue_q == $past(ue_addr)));

    a_r10_ue_keeps: assert property (@(posedge clk) disable iff (rst)
        (ue_held && !clr_w) |=> (ue_held && $stable(ue_q)));

    a_r11_ue_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_w && !ue_valid) |=> !ue_held);
endmodule

bind ecc_addr_log eal_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .CW     (CW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce_valid  (ce_valid),
    .ue_valid  (ue_valid),
    .ue_addr   (ue_addr),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ce_empty  (ce_empty),
    .ue_held   (ue_held),
    .ce_count  (ce_count),
    .ue_q      (ue_q)
);

// File: tb/ecc_addr_log_bench.sv
module ecc_addr_log_bench;
    localparam int unsigned AW = 32;
    localparam int unsigned DW = 32;
    localparam int unsigned DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          ce_valid, ue_valid, reg_wr, reg_sel;
    logic [AW-1:0] ce_addr, ue_addr;
    logic [DW-1:0] reg_wdata, reg_rdata;
    logic          ce_empty, ue_held;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [AW-1:0] exp_q[$];
    logic          exp_held;
    logic [AW-1:0] exp_ue;

    always #4 clk = ~clk;

    ecc_addr_log #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u_ecc_addr_log (
        .clk(clk), .rst(rst), .ce_valid(ce_valid), .ce_addr(ce_addr),
        .ue_valid(ue_valid), .ue_addr(ue_addr), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ce_empty(ce_empty), .ue_held(ue_held)
    );

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and updates the expected model
    task automatic step(input logic cv, input logic [AW-1:0] ca,
                        input logic uv, input logic [AW-1:0] ua,
                        input logic wr, input logic sel, input logic [DW-1:0] wd);
        @(negedge clk);
        ce_valid = cv; ce_addr = ca; ue_valid = uv; ue_addr = ua;
        reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        @(posedge clk);
        if (wr && !sel && wd == DW'(1) && exp_q.size() > 0) void'(exp_q.pop_front());
        if (cv && exp_q.size() < DEPTH) exp_q.push_back(ca);
        if (wr && sel) begin exp_held = 1'b0; exp_ue = '0; end
        if (uv && !exp_held) begin exp_held = 1'b1; exp_ue = ua; end
        #1;
        ce_valid = 0; ue_valid = 0; reg_wr = 0;
    endtask

    // Monitor: compares both registers against the model
    task automatic monitor(input string req);
        logic [AW-1:0] h;
        h = (exp_q.size() > 0) ? exp_q[0] : '0;
        reg_wr = 0; reg_sel = 0; #1;
        chk(req, "ce head", reg_rdata, DW'(h));
        chk(req, "ce_empty", DW'(ce_empty), DW'(exp_q.size() == 0));
        reg_sel = 1; #1;
        chk(req, "ue reg", reg_rdata, DW'(exp_ue));
        chk(req, "ue_held", DW'(ue_held), DW'(exp_held));
    endtask

    task automatic ce_ev(input logic [AW-1:0] a, input string req);
        step(1, a, 0, '0, 0, 0, '0); monitor(req);
    endtask

    task automatic pop(input string req);
        step(0, '0, 0, '0, 1, 0, DW'(1)); monitor(req);
    endtask

    initial begin
        ce_valid = 0; ue_valid = 0; reg_wr = 0; reg_sel = 0;
        ce_addr = '0; ue_addr = '0; reg_wdata = '0;
        exp_held = 0; exp_ue = '0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        monitor("R1");

        ce_ev(32'h0000_1000, "R2");
        ce_ev(32'h0000_2040, "R2");
        ce_ev(32'hDEAD_0080, "R2");
        ce_ev(32'h0000_4000, "R3");
        ce_ev(32'hBAD0_5555, "R3");                 // log full: dropped
        step(0, '0, 0, '0, 1, 0, DW'(2)); monitor("R5");
        step(0, '0, 0, '0, 1, 0, DW'(3)); monitor("R5");
        pop("R4");
        ce_ev(32'h0000_6000, "R2");                 // full again
        step(1, 32'h0000_7777, 0, '0, 1, 0, DW'(1)); monitor("R8");
        pop("R4"); pop("R4"); pop("R4"); pop("R4");
        pop("R6"); pop("R6");                       // empty pops
        ce_ev(32'h0000_ABC0, "R7");
        ce_ev(32'h0000_ABC0, "R7");
        ce_ev(32'h0000_ABC0, "R7");
        pop("R7"); pop("R7"); pop("R7"); pop("R6");

        step(0, '0, 1, 32'hC0DE_0100, 0, 0, '0); monitor("R9");
        step(0, '0, 1, 32'hC0DE_0200, 0, 0, '0); monitor("R10");
        step(1, 32'h0000_0010, 1, 32'hC0DE_0300, 0, 0, '0); monitor("R10");
        step(0, '0, 0, '0, 1, 1, DW'(7)); monitor("R11");
        step(0, '0, 1, 32'hC0DE_0400, 0, 0, '0); monitor("R9");
        step(0, '0, 1, 32'hC0DE_0500, 1, 1, DW'(0)); monitor("R11");
        pop("R4");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule